// File: doc/BRIEF.md
# Packed 12-bit Symbol Error Corrector

This block takes the output of a Reed-Solomon locator and evaluator (up to `MAX_ERR` pairs of symbol position and 12-bit error value) and applies them to a byte buffer. The buffer holds a data page with its spare bytes directly after it, at one contiguous address space. Codeword symbols are 12 bits wide and packed over the bytes with a 4-bit front offset. Symbol 0 therefore covers only byte 0, and every later symbol covers one full byte and one nibble of a neighbouring byte. When the page size leaves a remainder of two bytes modulo three, one symbol straddles the last page byte and the first spare byte.

A request is taken on a one-cycle `start` strobe, together with the error count and the packed position and value vectors. The controller first checks every entry in use, all in the same cycle. If any entry is invalid, it writes nothing and reports failure. Otherwise it applies the corrections one after another, in entry order. Each correction is a read-modify-write of its first byte followed by a read-modify-write of its second byte. The buffer is reached through a single-port RAM interface with one cycle of read latency. The request ends with a one-cycle `done` pulse carrying either the number of symbols corrected or the fail flag.

States:

- `S_IDLE`: waits for `start` and latches the request. It leads to `S_CHECK`.
- `S_CHECK`: judges the whole request. It leads to `S_DONE` on a fault or a zero count, and otherwise to `S_RD_A`.
- `S_RD_A`: reads the first byte of the current symbol. It leads to `S_WR_A`. For symbol 0 it makes no access and leads to `S_RD_B`.
- `S_WR_A`: writes the first byte back, XORed with its part of the error value. It leads to `S_RD_B`.
- `S_RD_B`: reads the second byte. It leads to `S_WR_B`.
- `S_WR_B`: writes the second byte back. It leads to `S_DONE` after the last entry, and otherwise to `S_RD_A` for the next entry.
- `S_DONE`: raises `done`. It leads to `S_IDLE`.

Top module: `rsfix_corrector`

## Requirements
- R1: For an odd position p, byte floor(3p/2) is XORed with value bits 11:4, and byte floor(3p/2)+1 is XORed with value bits 3:0 placed in its bits 7:4; its low nibble is left as it was.
- R2: For an even position p > 0, byte 3p/2−1 is XORed with value bits 11:8 placed in its bits 3:0, and byte 3p/2 is XORed with value bits 7:0.
- R3: Position 0 with value bits 11:8 all zero XORs only byte 0, with value bits 7:0; no other byte changes.
- R4: Position 0 with any of value bits 11:8 set makes the request fail.
- R5: A position above `MAX_POS` in any entry in use makes the request fail.
- R6: An error count above `MAX_ERR` makes the request fail.
- R7: A failed request writes no byte of the buffer.
- R8: Each request ends with `done` high for exactly one cycle. On success, `fixed_cnt` equals the error count and `fail` is 0. On failure, `fail` is 1 and `fixed_cnt` is 0.
- R9: The symbol that spans the page end puts value bits 11:4 into the last page byte and bits 3:0 into the high nibble of the first spare byte.
- R10: Entries are applied in order, each as a read and then a write of the same address, so entries that share a byte or repeat a position add up by XOR.
- R11: A `start` pulse while a request is in progress is ignored.
- R12: An error count of zero completes with `fixed_cnt` 0 and `fail` 0, and writes nothing.
- R13: The read and write strobes are never high together. Every write goes to the address read in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| err_cnt | input | CNT_W | Number of entries in use |
| err_pos | input | MAX_ERR*POS_W | Symbol positions, entry i at bits i*POS_W upward |
| err_val | input | MAX_ERR*12 | Error values, entry i at bits i*12 upward |
| mem_rd_en | output | 1 | Buffer read strobe; data arrives on the next cycle |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_addr | output | ADDR_W | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Request was uncorrectable; valid with `done` |
| fixed_cnt | output | CNT_W | Symbols corrected; valid with `done` |

## Verification
The bench builds the block with a 68-byte page, a 16-byte spare area, `MAX_POS` = 49, 7-bit positions and `MAX_ERR` = 4. With a page size of 68, the symbol at position 45 straddles the page end, as in the full-size case. The short buffer lets the bench sweep every valid position with several error values, and every ordered pair of positions, so all shared-nibble neighbours and repeated positions are covered. Positions up to 127 reach well past `MAX_POS`. After each request the bench compares the whole buffer against a model computed from the mapping rules.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;

    localparam int SYM_W = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RD_A,
        S_WR_A,
        S_RD_B,
        S_WR_B,
        S_DONE
    } fix_state_t;

endpackage

// File: rtl/rsfix_sym_check.sv
module rsfix_sym_check
    import rsfix_pkg::*;
#(
    parameter int POS_W   = 11,
    parameter int MAX_POS = 1374
) (
    input  logic             active,
    input  logic [POS_W-1:0] pos,
    input  logic [SYM_W-1:0] val,
    output logic             invalid
);

    logic beyond_end;
    logic lead_overflow;

    // A position past the last codeword symbol, or high bits on the
    // half-sized lead symbol, cannot be mapped onto the buffer.
    assign beyond_end    = pos > POS_W'(MAX_POS);
    assign lead_overflow = (pos == '0) && (val[11:8] != 4'h0);
    assign invalid       = active && (beyond_end || lead_overflow);

endmodule

// File: rtl/rsfix_sym_map.sv
module rsfix_sym_map
    import rsfix_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int ADDR_W = 12
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SYM_W-1:0]  val,
    output logic [ADDR_W-1:0] addr_a,
    output logic [7:0]        mask_a,
    output logic              skip_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic [7:0]        mask_b
);

    localparam int TW = POS_W + 2;

    logic [TW-1:0] triple;
    logic [TW-1:0] half;
    logic          odd;

    // Symbol p starts at bit 12p-4 of the buffer.
    assign triple = {2'b00, pos} + {1'b0, pos, 1'b0};
    assign half   = triple >> 1;
    assign odd    = pos[0];

    always_comb begin
        if (odd) begin
            addr_a = ADDR_W'(half);
            mask_a = val[11:4];
            addr_b = ADDR_W'(half + TW'(1));
            mask_b = {val[3:0], 4'h0};
        end else begin
            addr_a = ADDR_W'(half - TW'(1));
            mask_a = {4'h0, val[11:8]};
            addr_b = ADDR_W'(half);
            mask_b = val[7:0];
        end
        skip_a = (pos == '0);
    end

endmodule

// File: rtl/rsfix_corrector.sv
module rsfix_corrector
    import rsfix_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MAX_POS     = 1374,
    parameter int POS_W       = 11,
    parameter int MAX_ERR     = 4,
    localparam int BUF_BYTES  = PAGE_BYTES + SPARE_BYTES,
    localparam int ADDR_W     = $clog2(BUF_BYTES),
    localparam int CNT_W      = $clog2(MAX_ERR + 1),
    localparam int IDX_W      = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         err_cnt,
    input  logic [MAX_ERR*POS_W-1:0] err_pos,
    input  logic [MAX_ERR*SYM_W-1:0] err_val,
    output logic                     mem_rd_en,
    output logic                     mem_wr_en,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata,
    output logic                     done,
    output logic                     fail,
    output logic [CNT_W-1:0]         fixed_cnt
);

    fix_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_q [MAX_ERR];
    logic [SYM_W-1:0] val_q [MAX_ERR];
    logic             bad_q;

    logic [MAX_ERR-1:0] invalid_w;
    logic               request_bad;
    logic               last_entry;

    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [7:0]        mask_a, mask_b;
    logic              skip_a;

    // One validity checker per entry, all judged in the same cycle.
    for (genvar i = 0; i < MAX_ERR; i++) begin : g_check
        rsfix_sym_check #(
            .POS_W   (POS_W),
            .MAX_POS (MAX_POS)
        ) u_check (
            .active  (cnt_q > CNT_W'(i)),
            .pos     (pos_q[i]),
            .val     (val_q[i]),
            .invalid (invalid_w[i])
        );
    end

    assign request_bad = (cnt_q > CNT_W'(MAX_ERR)) || (|invalid_w);
    assign last_entry  = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

    rsfix_sym_map #(
        .POS_W  (POS_W),
        .ADDR_W (ADDR_W)
    ) u_map (
        .pos    (pos_q[idx_q]),
        .val    (val_q[idx_q]),
        .addr_a (addr_a),
        .mask_a (mask_a),
        .skip_a (skip_a),
        .addr_b (addr_b),
        .mask_b (mask_b)
    );

    // State register and request storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            bad_q   <= 1'b0;
            for (int i = 0; i < MAX_ERR; i++) begin
                pos_q[i] <= '0;
                val_q[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cnt_q <= err_cnt;
                        idx_q <= '0;
                        bad_q <= 1'b0;
                        for (int i = 0; i < MAX_ERR; i++) begin
                            pos_q[i] <= err_pos[i*POS_W +: POS_W];
                            val_q[i] <= err_val[i*SYM_W +: SYM_W];
                        end
                    end
                end
                S_CHECK: bad_q <= request_bad;
                S_WR_B:  idx_q <= idx_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        fail      = 1'b0;
        fixed_cnt = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_CHECK;
            end
            S_CHECK: begin
                state_d = (request_bad || cnt_q == '0) ? S_DONE : S_RD_A;
            end
            S_RD_A: begin
                mem_rd_en = !skip_a;
                mem_addr  = addr_a;
                state_d   = skip_a ? S_RD_B : S_WR_A;
            end
            S_WR_A: begin
                mem_wr_en = 1'b1;
                mem_addr  = addr_a;
                mem_wdata = mem_rdata ^ mask_a;
                state_d   = S_RD_B;
            end
            S_RD_B: begin
                mem_rd_en = 1'b1;
                mem_addr  = addr_b;
                state_d   = S_WR_B;
            end
            S_WR_B: begin
                mem_wr_en = 1'b1;
                mem_addr  = addr_b;
                mem_wdata = mem_rdata ^ mask_b;
                state_d   = last_entry ? S_DONE : S_RD_A;
            end
            S_DONE: begin
                done      = 1'b1;
                fail      = bad_q;
                fixed_cnt = bad_q ? '0 : cnt_q;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr))); // R13
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en})); // R13
    AST_NO_WR_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !bad_q); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_FAIL_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fixed_cnt == '0)); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (fixed_cnt <= CNT_W'(MAX_ERR))); // R6
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_DONE) |=> $stable(cnt_q)); // R11

endmodule

// File: tb/rsfix_corrector_bench.sv
module rsfix_corrector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE_B  = 68;
    localparam int SPARE_B = 16;
    localparam int MAXP    = 49;
    localparam int PW      = 7;
    localparam int NE      = 4;
    localparam int BUF_B   = PAGE_B + SPARE_B;
    localparam int AW      = $clog2(BUF_B);
    localparam int CW      = $clog2(NE + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CW-1:0]    err_cnt = '0;
    logic [NE*PW-1:0] err_pos = '0;
    logic [NE*12-1:0] err_val = '0;
    logic             mem_rd_en, mem_wr_en;
    logic [AW-1:0]    mem_addr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata = '0;
    logic             done, fail;
    logic [CW-1:0]    fixed_cnt;

    logic [7:0] mem [BUF_B];
    logic [7:0] ref_mem [BUF_B];
    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsfix_corrector #(
        .PAGE_BYTES  (PAGE_B),
        .SPARE_BYTES (SPARE_B),
        .MAX_POS     (MAXP),
        .POS_W       (PW),
        .MAX_ERR     (NE)
    ) u_rsfix_corrector (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .err_cnt   (err_cnt),
        .err_pos   (err_pos),
        .err_val   (err_val),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .fail      (fail),
        .fixed_cnt (fixed_cnt)
    );

    // Byte RAM with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < BUF_B; i++) begin
            mem[i]     = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
            ref_mem[i] = mem[i];
        end
    endtask

    // Reference mapping from R1, R2, R3, R9.
    task automatic model_apply(input int p, input int v);
        int b;
        if (p % 2 == 1) begin
            b = (3 * p - 1) / 2;
            ref_mem[b]   ^= 8'((v >> 4) & 8'hFF);
            ref_mem[b+1] ^= 8'((v & 4'hF) << 4);
        end else begin
            b = 3 * p / 2;
            if (p > 0) ref_mem[b-1] ^= 8'((v >> 8) & 4'hF);
            ref_mem[b] ^= 8'(v & 8'hFF);
        end
    endtask

    task automatic run(input int n, input logic [NE*PW-1:0] pv,
                       input logic [NE*12-1:0] vv, input bit poke, input string req);
        bit ok;
        int cyc;
        ok = (n <= NE);
        for (int i = 0; i < NE; i++) begin
            if (i < n) begin
                if (int'(pv[i*PW +: PW]) > MAXP) ok = 0;
                if (pv[i*PW +: PW] == '0 && vv[i*12+8 +: 4] != 4'h0) ok = 0;
            end
        end
        if (ok) for (int i = 0; i < n; i++)
            model_apply(int'(pv[i*PW +: PW]), int'(vv[i*12 +: 12]));
        @(negedge clk);
        err_cnt = CW'(n);
        err_pos = pv;
        err_val = vv;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                err_cnt = CW'(1);
                err_pos = {NE{PW'(10)}};
                err_val = {NE{12'hFFF}};
                start   = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(done, {req, " done"}, 0, 1);
        check(fail == !ok, {req, " R8 fail"}, fail, !ok);
        check(fixed_cnt == (ok ? CW'(n) : CW'(0)), {req, " R8 count"},
              fixed_cnt, ok ? n : 0);
        @(negedge clk);
        check(!done, {req, " R8 pulse"}, done, 0);
        begin
            int bad_at;
            bad_at = -1;
            for (int i = 0; i < BUF_B; i++)
                if (mem[i] !== ref_mem[i] && bad_at < 0) bad_at = i;
            if (bad_at >= 0)
                check(0, {req, " buffer"}, mem[bad_at], ref_mem[bad_at]);
            else
                check(1, req, 0, 0);
        end
    endtask

    function automatic logic [NE*PW-1:0] pk_pos(input int a, input int b, input int c, input int d);
        return {PW'(d), PW'(c), PW'(b), PW'(a)};
    endfunction

    function automatic logic [NE*12-1:0] pk_val(input int a, input int b, input int c, input int d);
        return {12'(d), 12'(c), 12'(b), 12'(a)};
    endfunction

    initial begin
        int vals [4] = '{12'hFFF, 12'h0A5, 12'h5A0, 12'h001};
        fill(1);
        repeat (3) @(negedge clk);
        check(!done && !mem_rd_en && !mem_wr_en, "reset", done, 0);
        rst_n = 1'b1;
        // R1 R2 R3 R4 R5 R9: every position with several values, some invalid
        for (int p = 0; p <= MAXP + 4; p++)
            for (int k = 0; k < 4; k++)
                run(1, pk_pos(p, 0, 0, 0), pk_val(vals[k], 0, 0, 0), 0,
                    (p == 45) ? "R9 split" : (p == 0) ? "R3 R4 lead" :
                    (p > MAXP) ? "R5 R7 range" : (p % 2 == 1) ? "R1 odd" : "R2 even");
        // R10: every ordered pair, neighbours and repeats included
        for (int a = 0; a <= MAXP; a++)
            for (int b = 0; b <= MAXP; b++)
                run(2, pk_pos(a, b, 0, 0), pk_val(12'h0F3 ^ a, 12'hC3E ^ b, 0, 0), 0, "R10 pair");
        run(4, pk_pos(45, 44, 46, 45), pk_val(12'h123, 12'h456, 12'h789, 12'hABC), 0, "R10 four");
        run(4, pk_pos(3, 9, 120, 7), pk_val(1, 2, 3, 4), 0, "R5 R7 late bad");
        run(4, pk_pos(3, 9, 0, 7), pk_val(1, 2, 12'h100, 4), 0, "R4 R7 lead bad");
        run(3, pk_pos(3, 9, 5, 99), pk_val(1, 2, 3, 12'hFFF), 0, "R8 unused slot ignored");
        run(5, pk_pos(3, 9, 5, 7), pk_val(1, 2, 3, 4), 0, "R6 R7 count");
        run(7, pk_pos(3, 9, 5, 7), pk_val(1, 2, 3, 4), 0, "R6 count max");
        run(0, pk_pos(3, 9, 5, 7), pk_val(1, 2, 3, 4), 0, "R12 zero");
        run(1, pk_pos(20, 0, 0, 0), pk_val(12'h9C6, 0, 0, 0), 1, "R11 busy start");
        run(2, pk_pos(31, 32, 0, 0), pk_val(12'h777, 12'h888, 0, 0), 1, "R11 R13 busy start");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule